// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits between a 32-bit core and a byte-addressed data memory whose port is one 32-bit word wide. A word covers four consecutive byte addresses. For a store, the core presents the low bits of the effective address, the access size and the store data. The block answers with four byte-write enables and the store data copied onto every lane that could be written. For a load, the core presents the raw memory word together with the same address and size information. The block picks out the addressed byte, halfword or word and widens it to 32 bits, either with sign extension or with zero extension.

A run-time input, normally driven from a software-controlled flag, selects how byte addresses map onto lanes:
- In little-endian mode the lowest byte address holds the least-significant byte.
- In big-endian mode the lowest byte address holds the most-significant byte, so the mapping is mirrored.

Accesses that break natural alignment are not split. They raise an error for one cycle, and no write strobe is produced.

Control is a four-state machine that is reloaded on every clock edge:
- `ST_IDLE`: no request was sampled.
- `ST_STORE`: an aligned store was sampled.
- `ST_LOAD`: an aligned load was sampled.
- `ST_FAULT`: a misaligned or reserved-size request was sampled.

The transitions are:
- From any state, a cycle with `req_valid` low leads to `ST_IDLE`.
- A valid request with a bad offset or size leads to `ST_FAULT`.
- A valid, aligned request with `req_store` high leads to `ST_STORE`.
- A valid, aligned request with `req_store` low leads to `ST_LOAD`.

All results are registered. They appear in the cycle after the request is sampled and last for that one cycle only.

Top module: `lsu_lane_aligner`

## Requirements
- R1: While `rst_n` is low, `mem_we`, `mem_be`, `mem_wdata`, `ld_valid`, `ld_data` and `misalign_err` are all zero, even if a request is presented.
- R2: A clock edge with `req_valid` low makes every output zero in the following cycle.
- R3: The results of a request sampled at edge N are visible between edge N and edge N+1 only. They clear at the next edge unless a new request is sampled there.
- R4: The request is in error in any of these cases: `req_size` is 2'b11 (reserved); `req_size` is 2'b10 (word) with `req_byte_off` not equal to 2'b00; `req_size` is 2'b01 (halfword) with `req_byte_off[0]` equal to 1. In that case `misalign_err` is 1 in the next cycle, and `mem_we`, `ld_valid` and `mem_be` (4'b0000) are all low.
- R5: A byte store (`req_size` 2'b00) drives `mem_wdata` with `req_wdata[7:0]` repeated in all four lanes, where lane i is bits [8i+7:8i]. Exactly one enable `mem_be[i]` is set: i equals the offset in little-endian mode and 3 minus the offset in big-endian mode.
- R6: A halfword store (`req_size` 2'b01) drives `req_wdata[15:0]` into both halves. The enables are 4'b0011 for little-endian offset 0 and for big-endian offset 2. They are 4'b1100 for little-endian offset 2 and for big-endian offset 0.
- R7: A word store (`req_size` 2'b10, offset 0) drives `mem_be` = 4'b1111 and passes `req_wdata` through unchanged in either mode.
- R8: A byte load returns the lane selected as in R5. The result is zero-extended when `req_unsigned` is 1 and sign-extended from bit 7 when it is 0.
- R9: A halfword load returns `mem_rdata[15:0]` for little-endian offset 0 and for big-endian offset 2. It returns `mem_rdata[31:16]` for little-endian offset 2 and for big-endian offset 0. The result is zero-extended when `req_unsigned` is 1 and sign-extended from bit 15 when it is 0.
- R10: A word load returns `mem_rdata` unchanged. `big_endian` and `req_unsigned` have no effect on it.
- R11: `big_endian` is sampled with each request. Back-to-back requests that use different modes are each mapped by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Load widening: 1 = zero-extend, 0 = sign-extend |
| req_byte_off | input | 2 | Low two bits of the effective address |
| req_wdata | input | 32 | Store data, right-justified |
| big_endian | input | 1 | Lane mapping mode: 1 = big-endian, 0 = little-endian |
| mem_rdata | input | 32 | Raw memory word for a load, presented with the request |
| mem_we | output | 1 | Write strobe towards memory |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| ld_valid | output | 1 | `ld_data` holds a load result |
| ld_data | output | 32 | Extracted and widened load value |
| misalign_err | output | 1 | The last sampled request broke alignment or used a reserved size |

## Verification
Because the state is rebuilt from the inputs at every edge, a wrong state or a wrong lane computation shows up at the ports in the very next cycle. It can appear as:
- a write strobe without a store;
- more or fewer enables than the access size implies;
- a mirrored lane;
- a missing error pulse.

The bench therefore compares every output in every cycle against an independent model. That model maps byte addresses to lanes one byte at a time, for every offset, size and mode. Back-to-back requests that switch mode show that no mode or state carries over from one cycle to the next.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Access size as carried on req_size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Kind of result presented in the current cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_STORE = 2'b01,
        ST_LOAD  = 2'b10,
        ST_FAULT = 2'b11
    } align_state_e;

endpackage

// File: rtl/lsa_lane_base.sv
// Alignment test and lowest-lane computation for one access.
module lsa_lane_base
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NBYTES)
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic               big_endian_i,
    output logic               aligned_o,
    output logic [OFF_W-1:0]   base_lane_o,
    output logic [OFF_W:0]     span_o
);

    logic [OFF_W-1:0] low_mask;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: span_o = (OFF_W+1)'(1);
            SZ_HALF: span_o = (OFF_W+1)'(2);
            default: span_o = (OFF_W+1)'(NBYTES);
        endcase
    end

    // The span is a power of two, so span-1 masks the offset bits that must be zero.
    assign low_mask  = span_o[OFF_W-1:0] - 1'b1;
    assign aligned_o = (size_i != SZ_RSVD) && ((off_i & low_mask) == '0);

    // Mirror mode: lowest lane = NBYTES - off - span, taken modulo NBYTES.
    assign base_lane_o = big_endian_i ? (OFF_W'(0) - off_i - span_o[OFF_W-1:0])
                                      : off_i;

endmodule

// File: rtl/lsa_store_lanes.sv
// Byte enables and lane-replicated write data.
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NBYTES)
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   base_lane_i,
    input  logic [OFF_W:0]     span_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NBYTES-1:0]  be_o,
    output logic [DATA_W-1:0]  wdata_o
);

    logic [OFF_W+1:0] lo_w;
    logic [OFF_W+1:0] hi_w;

    assign lo_w = {2'b00, base_lane_i};
    assign hi_w = lo_w + {1'b0, span_i};

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam logic [OFF_W+1:0] LANE = (OFF_W+2)'(i);
        assign be_o[i] = (LANE >= lo_w) && (LANE < hi_w);
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE: wdata_o = {NBYTES{wdata_i[7:0]}};
            SZ_HALF: wdata_o = {(NBYTES/2){wdata_i[15:0]}};
            default: wdata_o = wdata_i;
        endcase
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Lane selection and widening of a load.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NBYTES)
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   base_lane_i,
    input  logic               unsigned_i,
    input  logic [DATA_W-1:0]  rdata_i,
    output logic [DATA_W-1:0]  value_o
);

    logic [DATA_W-1:0] shifted;
    logic              fill_b;
    logic              fill_h;

    assign shifted = rdata_i >> {base_lane_i, 3'b000};
    assign fill_b  = !unsigned_i && shifted[7];
    assign fill_h  = !unsigned_i && shifted[15];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: value_o = {{(DATA_W-8){fill_b}}, shifted[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){fill_h}}, shifted[15:0]};
            default: value_o = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_lane_aligner.sv
// Registered load/store aligner with run-time lane ordering.
module lsu_lane_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_store,
    input  logic [1:0]                    req_size,
    input  logic                          req_unsigned,
    input  logic [$clog2(DATA_W/8)-1:0]   req_byte_off,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic                          big_endian,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          mem_we,
    output logic [DATA_W/8-1:0]           mem_be,
    output logic [DATA_W-1:0]             mem_wdata,
    output logic                          ld_valid,
    output logic [DATA_W-1:0]             ld_data,
    output logic                          misalign_err
);

    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    acc_size_e          size_c;
    logic               aligned_c;
    logic [OFF_W-1:0]   base_c;
    logic [OFF_W:0]     span_c;
    logic [NBYTES-1:0]  be_c;
    logic [DATA_W-1:0]  wdata_c;
    logic [DATA_W-1:0]  ldata_c;

    align_state_e       state_q;
    align_state_e       state_d;
    logic [NBYTES-1:0]  be_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  ldata_q;

    assign size_c = acc_size_e'(req_size);

    lsa_lane_base #(.DATA_W(DATA_W)) u_base (
        .size_i       (size_c),
        .off_i        (req_byte_off),
        .big_endian_i (big_endian),
        .aligned_o    (aligned_c),
        .base_lane_o  (base_c),
        .span_o       (span_c)
    );

    lsa_store_lanes #(.DATA_W(DATA_W)) u_store (
        .size_i      (size_c),
        .base_lane_i (base_c),
        .span_i      (span_c),
        .wdata_i     (req_wdata),
        .be_o        (be_c),
        .wdata_o     (wdata_c)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .size_i      (size_c),
        .base_lane_i (base_c),
        .unsigned_i  (req_unsigned),
        .rdata_i     (mem_rdata),
        .value_o     (ldata_c)
    );

    // Next-state decision.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!aligned_c)     state_d = ST_FAULT;
            else if (req_store) state_d = ST_STORE;
            else                state_d = ST_LOAD;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Payload registers; only shown when the state says so.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q    <= '0;
            wdata_q <= '0;
            ldata_q <= '0;
        end else begin
            be_q    <= be_c;
            wdata_q <= wdata_c;
            ldata_q <= ldata_c;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        mem_we       = 1'b0;
        mem_be       = '0;
        mem_wdata    = '0;
        ld_valid     = 1'b0;
        ld_data      = '0;
        misalign_err = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_STORE: begin
                mem_we    = 1'b1;
                mem_be    = be_q;
                mem_wdata = wdata_q;
            end
            ST_LOAD: begin
                ld_valid = 1'b1;
                ld_data  = ldata_q;
            end
            ST_FAULT: misalign_err = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsa_checker.sv
// Temporal properties of the aligner, bound onto the top module.
module lsa_checker #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NBYTES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_store,
    input logic [1:0]         req_size,
    input logic               req_unsigned,
    input logic [OFF_W-1:0]   req_byte_off,
    input logic               mem_we,
    input logic [NBYTES-1:0]  mem_be,
    input logic               ld_valid,
    input logic [DATA_W-1:0]  ld_data,
    input logic               misalign_err
);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_we && !ld_valid && !misalign_err && mem_be == '0));

    p_one_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, ld_valid, misalign_err}));

    p_no_strobe_unless_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> mem_be == '0);

    p_word_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b10 && req_byte_off != '0) |=> (misalign_err && !mem_we));

    p_half_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && req_byte_off[0]) |=> (misalign_err && !mem_we));

    p_byte_single_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b00) |=> (mem_we && $countones(mem_be) == 1));

    p_half_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b01 && !req_byte_off[0])
        |=> (mem_we && $countones(mem_be) == 2 && (mem_be & (mem_be >> 1)) != '0));

    p_word_all_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b10 && req_byte_off == '0)
        |=> (mem_we && mem_be == '1));

    p_unsigned_byte_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'b00 && req_unsigned)
        |=> (ld_valid && ld_data[DATA_W-1:8] == '0));

endmodule

bind lsu_lane_aligner lsa_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .req_byte_off (req_byte_off),
    .mem_we       (mem_we),
    .mem_be       (mem_be),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data),
    .misalign_err (misalign_err)
);

// File: tb/tb_lsu_lane_aligner.sv
`timescale 1ns/1ps
module tb_lsu_lane_aligner;

    localparam real HALF_PERIOD = 4.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_unsigned, big_endian;
    logic [1:0]  req_size, req_byte_off;
    logic [31:0] req_wdata, mem_rdata;
    logic        mem_we, ld_valid, misalign_err;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic        we;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        lv;
        logic [31:0] ld;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(HALF_PERIOD) clk = ~clk;

    lsu_lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_byte_off(req_byte_off),
        .req_wdata(req_wdata), .big_endian(big_endian), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .misalign_err(misalign_err)
    );

    // Lane that holds byte address a of a word in the chosen mode.
    function automatic int lane_of(int a, logic bem);
        return bem ? 3 - a : a;
    endfunction

    function automatic logic [7:0] byte_at(logic [31:0] w, int a, logic bem);
        return w[8*lane_of(a, bem) +: 8];
    endfunction

    function automatic exp_t model(logic v, logic st, logic [1:0] sz, logic uns,
                                   logic [1:0] off, logic [31:0] wd, logic [31:0] rd,
                                   logic bem, string tag);
        exp_t e;
        int   o = int'(off);
        int   n;
        logic bad;
        logic [15:0] h;
        e.we = 0; e.be = 0; e.wd = 0; e.lv = 0; e.ld = 0; e.err = 0; e.tag = tag;
        if (!v) return e;
        bad = (sz == 2'b11) || (sz == 2'b10 && off != 2'b00) || (sz == 2'b01 && off[0]);
        if (bad) begin
            e.err = 1;
            return e;
        end
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        if (st) begin
            e.we = 1;
            for (int k = 0; k < n; k++) e.be[lane_of(o + k, bem)] = 1'b1;
            e.wd = (sz == 2'b00) ? {4{wd[7:0]}} : (sz == 2'b01) ? {2{wd[15:0]}} : wd;
        end else begin
            e.lv = 1;
            if (sz == 2'b00) begin
                e.ld = {{24{!uns && byte_at(rd, o, bem)[7]}}, byte_at(rd, o, bem)};
            end else if (sz == 2'b01) begin
                h = bem ? {byte_at(rd, o, bem), byte_at(rd, o + 1, bem)}
                        : {byte_at(rd, o + 1, bem), byte_at(rd, o, bem)};
                e.ld = {{16{!uns && h[15]}}, h};
            end else begin
                e.ld = bem ? {byte_at(rd, 0, bem), byte_at(rd, 1, bem), byte_at(rd, 2, bem), byte_at(rd, 3, bem)}
                           : {byte_at(rd, 3, bem), byte_at(rd, 2, bem), byte_at(rd, 1, bem), byte_at(rd, 0, bem)};
            end
        end
        return e;
    endfunction

    task automatic drive(logic v, logic st, logic [1:0] sz, logic uns, logic [1:0] off,
                         logic [31:0] wd, logic [31:0] rd, logic bem, string tag);
        @(negedge clk);
        req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
        req_byte_off = off; req_wdata = wd; mem_rdata = rd; big_endian = bem;
        exp_q.push_back(model(v, st, sz, uns, off, wd, rd, bem, tag));
    endtask

    task automatic idle(string tag);
        drive(1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0, 32'h0, 1'b0, tag);
    endtask

    // Monitor: sample 2 ns after each rising edge and compare with the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (mem_we !== e.we || mem_be !== e.be || mem_wdata !== e.wd ||
                    ld_valid !== e.lv || ld_data !== e.ld || misalign_err !== e.err) begin
                    n_fails++;
                    $display("FAIL %s: got we=%b be=%b wd=%h lv=%b ld=%h err=%b exp we=%b be=%b wd=%h lv=%b ld=%h err=%b",
                             e.tag, mem_we, mem_be, mem_wdata, ld_valid, ld_data, misalign_err,
                             e.we, e.be, e.wd, e.lv, e.ld, e.err);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b1; req_store = 1'b1; req_size = 2'b10; req_unsigned = 1'b0;
        req_byte_off = 2'b00; req_wdata = 32'hDEADBEEF; mem_rdata = 32'h12345678; big_endian = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs held at zero in reset despite a pending request.
        n_checks++;
        if (mem_we !== 1'b0 || mem_be !== 4'h0 || mem_wdata !== 32'h0 || ld_valid !== 1'b0 ||
            ld_data !== 32'h0 || misalign_err !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset: got we=%b be=%b wd=%h lv=%b ld=%h err=%b exp all zero",
                     mem_we, mem_be, mem_wdata, ld_valid, ld_data, misalign_err);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;

        idle("R2 idle after reset");
        idle("R2 idle repeated");

        // R5 byte stores, every offset, both modes.
        for (int e = 0; e < 2; e++)
            for (int o = 0; o < 4; o++)
                drive(1, 1, 2'b00, 0, 2'(o), 32'hA1B2C3D4 ^ 32'(o * 17), 32'h0, e[0], "R5 byte store");

        // R6 halfword stores.
        for (int e = 0; e < 2; e++)
            for (int o = 0; o < 4; o += 2)
                drive(1, 1, 2'b01, 0, 2'(o), 32'h5566_9A7B + 32'(o), 32'h0, e[0], "R6 half store");

        // R7 word stores.
        drive(1, 1, 2'b10, 0, 2'b00, 32'h0BAD_F00D, 32'h0, 1'b0, "R7 word store LE");
        drive(1, 1, 2'b10, 0, 2'b00, 32'hCAFE_1234, 32'h0, 1'b1, "R7 word store BE");

        // R3: result lasts one cycle only.
        drive(1, 1, 2'b00, 0, 2'b01, 32'h0000_00EE, 32'h0, 1'b0, "R3 store before gap");
        idle("R3 cleared after one cycle");

        // R4 misaligned and reserved accesses, stores and loads.
        for (int o = 1; o < 4; o++) begin
            drive(1, 1, 2'b10, 0, 2'(o), 32'hFFFF_FFFF, 32'h0, 1'b0, "R4 word store misaligned");
            drive(1, 0, 2'b10, 0, 2'(o), 32'h0, 32'h8765_4321, 1'b1, "R4 word load misaligned");
        end
        drive(1, 1, 2'b01, 0, 2'b01, 32'h1234, 32'h0, 1'b0, "R4 half store off1");
        drive(1, 0, 2'b01, 1, 2'b11, 32'h0, 32'hFFFF_FFFF, 1'b1, "R4 half load off3");
        drive(1, 1, 2'b11, 0, 2'b00, 32'h1, 32'h0, 1'b0, "R4 reserved size store");
        drive(1, 0, 2'b11, 0, 2'b00, 32'h0, 32'h1, 1'b1, "R4 reserved size load");
        idle("R4 error clears");

        // R8 byte loads, signed and unsigned, both modes.
        for (int e = 0; e < 2; e++)
            for (int u = 0; u < 2; u++)
                for (int o = 0; o < 4; o++)
                    drive(1, 0, 2'b00, u[0], 2'(o), 32'h0, 32'h80F1_7F23, e[0], "R8 byte load");

        // R9 halfword loads.
        for (int e = 0; e < 2; e++)
            for (int u = 0; u < 2; u++)
                for (int o = 0; o < 4; o += 2)
                    drive(1, 0, 2'b01, u[0], 2'(o), 32'h0, 32'h8001_7FFE, e[0], "R9 half load");

        // R10 word loads ignore mode and unsigned flag.
        for (int e = 0; e < 2; e++)
            for (int u = 0; u < 2; u++)
                drive(1, 0, 2'b10, u[0], 2'b00, 32'h0, 32'hF00D_8B31, e[0], "R10 word load");

        // R11 mode switched between back-to-back requests.
        drive(1, 0, 2'b00, 1, 2'b00, 32'h0, 32'h1122_3344, 1'b0, "R11 LE byte load");
        drive(1, 0, 2'b00, 1, 2'b00, 32'h0, 32'h1122_3344, 1'b1, "R11 BE byte load");
        drive(1, 1, 2'b01, 0, 2'b00, 32'h0000_ABCD, 32'h0, 1'b0, "R11 LE half store");
        drive(1, 1, 2'b01, 0, 2'b00, 32'h0000_ABCD, 32'h0, 1'b1, "R11 BE half store");
        idle("R2 final idle");

        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule